// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block shifts or rotates a 32-bit data word by an amount read from a general 32-bit register. It also produces the carry flag that the shift leaves behind. An execute stage presents one operation per valid strobe: the data word, the amount register, a two-bit operation code and the carry flag as it stands. One clock later the block returns the shifted word and the new carry.

Only the low byte of the amount register counts, so amounts from 0 to 255 must all be handled. Amounts of 32 and above have a fixed meaning for each operation, and these meanings differ from one another. A zero amount passes the word through and keeps the incoming carry. Rotation reduces the amount modulo 32. A nonzero amount that reduces to zero still takes bit 31 into the carry.

Top module: `regshift_unit`

## Requirements
- R1: Only `in_amount[7:0]` sets the shift count. Bits 31..8 have no effect, so a count byte of 0 with nonzero upper bits still acts as a zero amount.
- R2: Logical left (op code 0), count n in 1..31: the result is data shifted left by n with zeros filled in, and the carry is data bit (32 - n).
- R3: Logical left with n = 32 gives a zero result and takes the carry from data bit 0. Logical left or logical right (op code 1) with n from 33 to 255 gives a zero result and a zero carry.
- R4: Logical right (op code 1), n in 1..31: the result is data shifted right by n with zeros filled in, and the carry is data bit (n - 1).
- R5: Logical right with n = 32 gives a zero result, and the carry is data bit 31.
- R6: Arithmetic right (op code 2), n in 1..31: the vacated top bits are filled with copies of data bit 31, and the carry is data bit (n - 1).
- R7: Arithmetic right with n from 32 to 255 fills all 32 result bits with data bit 31, and the carry equals data bit 31.
- R8: For every op code, n = 0 makes the result equal to the data and the carry equal to `in_carry`.
- R9: Rotate right (op code 3) with r = n mod 32 nonzero gives the data rotated right by r, and the carry is data bit (r - 1).
- R10: Rotate right with n nonzero and r = 0 leaves the data unchanged as the result, and the carry is data bit 31.
- R11: `out_result` and `out_carry` are loaded on the rising edge at which `in_valid` is high, and `out_valid` is high for exactly the cycle after each strobe. Without a strobe, both outputs hold their values.
- R12: A synchronous reset (`rst_n` low at a rising edge) clears `out_valid`, `out_result` and `out_carry` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: the operands are valid this cycle |
| in_data | input | 32 | Word to be shifted |
| in_amount | input | 32 | Amount register; only bits 7..0 are used |
| in_op | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | High one cycle after a strobe |
| out_result | output | 32 | Shifted word, registered |
| out_carry | output | 1 | Updated carry flag, registered |

## Verification
The only state is the output register, so a fault inside the block shows up on the first `out_valid` cycle after the strobe that caused it. A mistake in decoding the count appears at the boundaries: at n = 31, 32 and 33, at n = 0 with upper bits set, and when a rotation count is a multiple of 32. At these points the carry bit is taken from a different place or forced to a fixed value. A register that loads when it should hold shows as outputs that change during idle cycles, so the idle gaps between strobes are checked as well.

// File: rtl/regshift_pkg.sv
// Package: shared operation codes for the register-amount shifter.
// Assumes a two-bit operation field driven by the decode stage.
package regshift_pkg;
    typedef enum logic [1:0] {
        OP_SHL = 2'd0,
        OP_SHR = 2'd1,
        OP_SAR = 2'd2,
        OP_ROTR = 2'd3
    } shift_op_e;
endpackage

// File: rtl/regshift_count.sv
// Module: regshift_count
// Picks the count byte out of the amount register and classifies it.
// Assumes the caller hands over only the count field; the upper bits are
// discarded one level up.
module regshift_count #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int ROT_W = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] cnt_field,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_is_zero,
    output logic [ROT_W-1:0] rot_cnt
);
    // Pass the count through and derive the zero flag and the rotate residue.
    always_comb begin
        cnt         = cnt_field;
        cnt_is_zero = (cnt_field == '0);
        rot_cnt     = cnt_field[ROT_W-1:0];
    end
endmodule

// File: rtl/regshift_core.sv
// Module: regshift_core
// Combinational shift and rotate with carry-out for all four op codes.
// Assumes the count has already been classified by regshift_count. The
// data word is widened by one bit so that the bit leaving the word falls
// into the spare position and becomes the carry. This covers counts of
// DATA_W and above with no special cases.
module regshift_core
    import regshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int ROT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cnt_is_zero,
    input  logic [ROT_W-1:0]  rot_cnt,
    input  shift_op_e         op,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    logic [DATA_W:0]          left_ext;
    logic [DATA_W:0]          right_ext;
    logic signed [DATA_W:0]   sar_ext;
    logic [2*DATA_W-1:0]      rot_ext;

    // Extended shifts: the spare bit catches the last bit shifted out.
    always_comb begin
        left_ext  = {1'b0, data} << cnt;
        right_ext = {data, 1'b0} >> cnt;
        sar_ext   = $signed({data, 1'b0}) >>> cnt;
        rot_ext   = {data, data} >> rot_cnt;
    end

    // Choose the result and carry for the op; a zero count passes everything through.
    always_comb begin
        result    = data;
        carry_out = carry_in;
        if (!cnt_is_zero) begin
            unique case (op)
                OP_SHL: begin
                    result    = left_ext[DATA_W-1:0];
                    carry_out = left_ext[DATA_W];
                end
                OP_SHR: begin
                    result    = right_ext[DATA_W:1];
                    carry_out = right_ext[0];
                end
                OP_SAR: begin
                    result    = sar_ext[DATA_W:1];
                    carry_out = sar_ext[0];
                end
                default: begin
                    result    = rot_ext[DATA_W-1:0];
                    carry_out = rot_ext[DATA_W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/regshift_unit.sv
// Module: regshift_unit (top)
// Register-amount shifter with carry-out. Each strobe is registered and
// the answer appears one cycle later. Assumes the operands are stable in
// the strobe cycle; only the low CNT_W bits of the amount register count.
module regshift_unit
    import regshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AREG_W = 32,
    parameter int CNT_W  = 8,
    localparam int ROT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AREG_W-1:0] in_amount,
    input  logic [1:0]        in_op,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_carry
);
    logic [CNT_W-1:0]  cnt;
    logic              cnt_is_zero;
    logic [ROT_W-1:0]  rot_cnt;
    logic [DATA_W-1:0] nxt_result;
    logic              nxt_carry;

    regshift_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_count (
        .cnt_field   (in_amount[CNT_W-1:0]),
        .cnt         (cnt),
        .cnt_is_zero (cnt_is_zero),
        .rot_cnt     (rot_cnt)
    );

    regshift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .data        (in_data),
        .cnt         (cnt),
        .cnt_is_zero (cnt_is_zero),
        .rot_cnt     (rot_cnt),
        .op          (shift_op_e'(in_op)),
        .carry_in    (in_carry),
        .result      (nxt_result),
        .carry_out   (nxt_carry)
    );

    // Output register: load on a strobe, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_carry  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt_result;
                out_carry  <= nxt_carry;
            end
        end
    end
endmodule

// File: rtl/regshift_unit_chk.sv
// Module: regshift_unit_chk
// Port-level properties of regshift_unit, attached with bind below.
// Assumes the fixed op codes of regshift_pkg.
module regshift_unit_chk
    import regshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AREG_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [AREG_W-1:0] in_amount,
    input logic [1:0]        in_op,
    input logic              in_carry,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_carry
);
    localparam int ROT_W = $clog2(DATA_W);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry))); // R11
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_amount[CNT_W-1:0] == '0) |=>
        (out_result == $past(in_data) && out_carry == $past(in_carry))); // R8
    AST_UPPER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_amount[CNT_W-1:0] == '0 && in_amount[AREG_W-1:CNT_W] != '0) |=>
        (out_result == $past(in_data))); // R1
    AST_SAR_FLOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SAR && in_amount[CNT_W-1:0] >= CNT_W'(DATA_W)) |=>
        (out_result == {DATA_W{$past(in_data[DATA_W-1])}} && out_carry == $past(in_data[DATA_W-1]))); // R7
    AST_WIDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_SHL || in_op == OP_SHR) && in_amount[CNT_W-1:0] > CNT_W'(DATA_W)) |=>
        (out_result == '0 && !out_carry)); // R3
    AST_ROT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ROTR && in_amount[ROT_W-1:0] == '0 && in_amount[CNT_W-1:0] != '0) |=>
        (out_result == $past(in_data) && out_carry == $past(in_data[DATA_W-1]))); // R10
endmodule

bind regshift_unit regshift_unit_chk #(.DATA_W(DATA_W), .AREG_W(AREG_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_amount  (in_amount),
    .in_op      (in_op),
    .in_carry   (in_carry),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
);

// File: tb/regshift_unit_test.sv
// Directed bench for regshift_unit: one task per scenario.
module regshift_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [31:0] in_amount = '0;
    logic [1:0]  in_op = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_carry;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    regshift_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_amount(in_amount), .in_op(in_op), .in_carry(in_carry),
        .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry)
    );

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Model written from the requirements; returns {carry, result}.
    function automatic logic [32:0] model(input logic [1:0] op, input logic [31:0] amt,
                                          input logic [31:0] d, input logic c);
        int n;
        int r;
        n = int'(amt[7:0]);
        if (n == 0) return {c, d};
        case (op)
            2'd0: begin
                if (n < 32) return {d[32-n], d << n};
                if (n == 32) return {d[0], 32'h0};
                return 33'h0;
            end
            2'd1: begin
                if (n < 32) return {d[n-1], d >> n};
                if (n == 32) return {d[31], 32'h0};
                return 33'h0;
            end
            2'd2: begin
                if (n < 32) return {d[n-1], 32'($signed(d) >>> n)};
                return {d[31], {32{d[31]}}};
            end
            default: begin
                r = n % 32;
                if (r == 0) return {d[31], d};
                return {d[r-1], (d >> r) | (d << (32 - r))};
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act_r, input logic act_c,
                         input logic [31:0] exp_r, input logic exp_c);
        total = total + 1;
        if (act_r !== exp_r || act_c !== exp_c) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h/%b expected=%h/%b", req, act_r, act_c, exp_r, exp_c);
        end
    endtask

    // One strobe; sample at the negedge after the loading edge.
    task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] amt,
                          input logic [31:0] d, input logic c);
        logic [32:0] exp;
        exp = model(op, amt, d, c);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_amount = amt; in_data = d; in_carry = c;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_result, out_carry, exp[31:0], exp[32]);
        total = total + 1;
        if (out_valid !== 1'b1) begin
            bad = bad + 1;
            $display("FAIL R11 valid: actual=%b expected=1", out_valid);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R12", out_result, out_carry, 32'h0, 1'b0);
        total = total + 1;
        if (out_valid !== 1'b0) begin
            bad = bad + 1;
            $display("FAIL R12 valid: actual=%b expected=0", out_valid);
        end
    endtask

    task automatic t_shl;
        run_op("R2", 2'd0, 32'd1, 32'h8000_0001, 1'b0);
        run_op("R2", 2'd0, 32'd31, 32'h0000_0003, 1'b0);
        run_op("R2", 2'd0, 32'd4, 32'hF123_4567, 1'b0);
        run_op("R3", 2'd0, 32'd32, 32'h0000_0001, 1'b0);
        run_op("R3", 2'd0, 32'd33, 32'hFFFF_FFFF, 1'b1);
        run_op("R3", 2'd0, 32'd255, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_shr;
        run_op("R4", 2'd1, 32'd1, 32'h0000_0003, 1'b0);
        run_op("R4", 2'd1, 32'd31, 32'hC000_0000, 1'b0);
        run_op("R5", 2'd1, 32'd32, 32'h8000_0000, 1'b0);
        run_op("R3", 2'd1, 32'd33, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_sar;
        run_op("R6", 2'd2, 32'd4, 32'h8000_00F8, 1'b0);
        run_op("R6", 2'd2, 32'd31, 32'h4000_0000, 1'b1);
        run_op("R7", 2'd2, 32'd32, 32'h8000_0000, 1'b0);
        run_op("R7", 2'd2, 32'd200, 32'h7FFF_FFFF, 1'b1);
    endtask

    task automatic t_ror;
        run_op("R9", 2'd3, 32'd8, 32'h1234_5680, 1'b0);
        run_op("R9", 2'd3, 32'd37, 32'h0000_0010, 1'b0);
        run_op("R10", 2'd3, 32'd32, 32'h8765_4321, 1'b0);
        run_op("R10", 2'd3, 32'd224, 32'h1234_5678, 1'b1);
    endtask

    task automatic t_zero;
        for (int op = 0; op < 4; op++) begin
            run_op("R8", 2'(op), 32'd0, 32'hA5A5_0F0F, 1'b1);
            run_op("R8", 2'(op), 32'd0, 32'h5A5A_F0F0, 1'b0);
        end
    endtask

    task automatic t_upper;
        run_op("R1", 2'd0, 32'hFFFF_FF00, 32'hDEAD_BEEF, 1'b1);
        run_op("R1", 2'd1, 32'h0000_0104, 32'hDEAD_BEEF, 1'b0);
        run_op("R1", 2'd3, 32'h8000_0020, 32'hDEAD_BEEF, 1'b0);
    endtask

    task automatic t_hold;
        logic [31:0] kept_r;
        logic        kept_c;
        run_op("R11", 2'd0, 32'd3, 32'h0000_0011, 1'b0);
        kept_r = out_result;
        kept_c = out_carry;
        for (int i = 0; i < 3; i++) begin
            in_data = 32'hFFFF_0000 ^ 32'(i); in_amount = 32'd5; in_op = 2'd1; in_carry = 1'b1;
            @(negedge clk);
            check("R11 hold", out_result, out_carry, kept_r, kept_c);
            total = total + 1;
            if (out_valid !== 1'b0) begin
                bad = bad + 1;
                $display("FAIL R11 idle valid: actual=%b expected=0", out_valid);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_shl();
        t_shr();
        t_sar();
        t_ror();
        t_zero();
        t_upper();
        t_hold();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule